// File: doc/BRIEF.md
# Multidrop Address-Tagged UART Receiver

This block turns an oversampled asynchronous serial line into characters. Each frame is a start bit, eight data bits sent least significant bit first, a ninth bit and one stop bit. In multidrop mode the ninth bit is an address/data marker rather than parity. A clock-enable pulse at sixteen times the bit rate paces the receiver. The line is synchronised into the clock domain, a falling edge is confirmed half a bit later, and every later bit is sampled at its centre.

Each completed character is classified and may be written into a three-entry receive queue. An entry holds the data byte and four per-character flags. While the receiver enable is low in multidrop mode, only address-marked characters are kept. A node can therefore sleep until it hears its own address and then turn its receiver on. In plain mode the ninth bit is checked as even parity. Framing errors and breaks also drive one-cycle pulse outputs, and these fire whether or not the character was kept.

Top module: `mdrop_uart_rx`

## Requirements
- R1: After reset the queue is empty: `rd_stat` and `rd_data` read all zeros, and `fe_pulse` and `brk_pulse` are low.
- R2: A frame is one low start bit, eight data bits least significant first, a ninth bit and a stop bit, each 16 ticks long. A low pulse on the line shorter than half a bit is not taken as a start bit and produces no character.
- R3: With `md_mode`=1, `rd_stat[5]` of a stored character equals the received ninth bit (1 = address, 0 = data), and no parity check is made.
- R4: With `md_mode`=1 and `rx_en`=0, a character whose ninth bit is 0 is discarded, and one whose ninth bit is 1 is stored.
- R5: With `rx_en`=1, every completed character is stored in either mode, provided the queue has room.
- R6: With `md_mode`=0, `rd_stat[5]` is 1 when the eight data bits plus the ninth bit hold an odd number of ones (even parity failed). With `rx_en`=0 in this mode, nothing is stored.
- R7: A stop bit sampled low sets `rd_stat[6]` of the stored character and gives a one-cycle `fe_pulse`, even if the character is discarded.
- R8: A frame whose data, ninth bit and stop bit are all zero is a break. It sets `rd_stat[7]` and `rd_stat[6]` and gives a `brk_pulse`. The receiver then waits for the line to go high before it looks for a new start bit.
- R9: The queue keeps up to three characters in arrival order. `rd_stat[0]` is 1 while it is not empty, `rd_stat[1]` is 1 while it holds three, and `rd_pop` removes the entry being shown.
- R10: A character that would be stored while the queue is full is lost, and `rd_stat[4]` is set on the most recently stored entry.
- R11: `rd_pop` while the queue is empty has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick16 | input | 1 | Sample enable at 16x the bit rate |
| rxd | input | 1 | Serial input, idle high |
| rx_en | input | 1 | Receiver enable |
| md_mode | input | 1 | 1 = ninth bit is address/data marker, 0 = even parity |
| rd_pop | input | 1 | Remove the head entry |
| rd_data | output | 8 | Head entry data (zero when empty) |
| rd_stat | output | 8 | [0] not empty, [1] full, [4] overrun, [5] marker/parity error, [6] framing error, [7] break |
| fe_pulse | output | 1 | One-cycle pulse on a framing error |
| brk_pulse | output | 1 | One-cycle pulse on a break |

## Verification
The bench targets several corner cases, each with a visible failure if the design gets it wrong:
- A short low glitch on the line. A design without the half-bit start check would invent a character.
- A data-marked character arriving while the receiver is disabled. A wrong design would let it into the queue.
- A bad stop bit on a discarded character. Tying the error pulse to the queue write would lose that pulse.
- An all-zero break followed by a held-low line. A receiver that re-arms at once would report extra frames.
- Bursts of up to five frames with no reads. These must show the fourth character dropped and the overrun flag on the third entry, not on the head.
- Constrained random frames across both modes.

// File: rtl/mdrop_rx_pkg.sv
package mdrop_rx_pkg;
    // status bit positions as seen on rd_stat
    localparam int ST_RDY  = 0;
    localparam int ST_FULL = 1;
    localparam int ST_OVR  = 4;
    localparam int ST_TAG  = 5;
    localparam int ST_FE   = 6;
    localparam int ST_BRK  = 7;
    localparam int STAT_W  = 8;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_START,
        RX_SHIFT,
        RX_HOLD
    } rx_state_e;
endpackage

// File: rtl/mdrop_rx_deser.sv
module mdrop_rx_deser
    import mdrop_rx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OSR    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              rxd,
    output logic              done,
    output logic [DATA_W-1:0] data,
    output logic              ninth,
    output logic              stop
);
    localparam int FRM_BITS = DATA_W + 2;
    localparam int CNT_W    = $clog2(OSR);
    localparam int IDX_W    = $clog2(FRM_BITS);
    localparam int HALF     = OSR / 2;

    typedef struct packed {
        logic                s1;
        logic                s2;
        rx_state_e           st;
        logic [CNT_W-1:0]    cnt;
        logic [IDX_W-1:0]    idx;
        logic [FRM_BITS-1:0] sh;
        logic                done;
    } deser_t;

    localparam deser_t RST_VAL = '{s1: 1'b1, s2: 1'b1, st: RX_IDLE,
                                   cnt: '0, idx: '0, sh: '0, done: 1'b0};

    deser_t q, d;

    always_comb begin
        d      = q;
        d.s1   = rxd;
        d.s2   = q.s1;
        d.done = 1'b0;
        if (tick) begin
            unique case (q.st)
                RX_IDLE: begin
                    if (!q.s2) begin
                        d.st  = RX_START;
                        d.cnt = '0;
                    end
                end
                RX_START: begin
                    if (q.cnt == CNT_W'(HALF - 1)) begin
                        d.cnt = '0;
                        d.idx = '0;
                        d.st  = q.s2 ? RX_IDLE : RX_SHIFT;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
                RX_SHIFT: begin
                    if (q.cnt == CNT_W'(OSR - 1)) begin
                        d.cnt = '0;
                        d.sh  = {q.s2, q.sh[FRM_BITS-1:1]};
                        if (q.idx == IDX_W'(FRM_BITS - 1)) begin
                            d.done = 1'b1;
                            // a low stop bit must see the line rise first
                            d.st   = q.s2 ? RX_IDLE : RX_HOLD;
                        end else begin
                            d.idx = q.idx + 1'b1;
                        end
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
                RX_HOLD: begin
                    if (q.s2) d.st = RX_IDLE;
                end
                default: d.st = RX_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= RST_VAL;
        else        q <= d;
    end

    assign done  = q.done;
    assign data  = q.sh[DATA_W-1:0];
    assign ninth = q.sh[DATA_W];
    assign stop  = q.sh[DATA_W+1];
endmodule

// File: rtl/mdrop_rx_fifo.sv
module mdrop_rx_fifo #(
    parameter int DEPTH   = 3,
    parameter int W       = 12,
    parameter int OVR_BIT = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  logic [W-1:0]               din,
    input  logic                       pop,
    input  logic                       mark,
    output logic [W-1:0]               dout,
    output logic [$clog2(DEPTH+1)-1:0] fill
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PTR_W-1:0]        wp;
        logic [PTR_W-1:0]        rp;
        logic [CNT_W-1:0]        cnt;
    } fifo_t;

    fifo_t q, d;

    function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    function automatic logic [PTR_W-1:0] ptr_prev(input logic [PTR_W-1:0] p);
        return (p == '0) ? PTR_W'(DEPTH - 1) : p - 1'b1;
    endfunction

    logic do_pop, do_push;

    always_comb begin
        d       = q;
        do_pop  = pop && (q.cnt != '0);
        do_push = push && (q.cnt != CNT_W'(DEPTH));
        if (mark && (q.cnt != '0)) d.mem[ptr_prev(q.wp)][OVR_BIT] = 1'b1;
        if (do_pop) d.rp = ptr_next(q.rp);
        if (do_push) begin
            d.mem[q.wp] = din;
            d.wp        = ptr_next(q.wp);
        end
        unique case ({do_push, do_pop})
            2'b10:   d.cnt = q.cnt + 1'b1;
            2'b01:   d.cnt = q.cnt - 1'b1;
            default: d.cnt = q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign dout = q.mem[q.rp];
    assign fill = q.cnt;
endmodule

// File: rtl/mdrop_uart_rx.sv
module mdrop_uart_rx
    import mdrop_rx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OSR    = 16,
    parameter int DEPTH  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick16,
    input  logic              rxd,
    input  logic              rx_en,
    input  logic              md_mode,
    input  logic              rd_pop,
    output logic [DATA_W-1:0] rd_data,
    output logic [STAT_W-1:0] rd_stat,
    output logic              fe_pulse,
    output logic              brk_pulse
);
    localparam int ENT_W = DATA_W + 4;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int E_OVR = DATA_W;

    typedef struct packed {
        logic fe;
        logic brk;
    } pulse_t;

    logic              frm_done, frm_ninth, frm_stop;
    logic [DATA_W-1:0] frm_data;
    logic              frm_tag, frm_fe, frm_brk, frm_keep, q_full, q_any;
    logic              fifo_push, fifo_mark;
    logic [ENT_W-1:0]  fifo_in, head;
    logic [CNT_W-1:0]  fill_cnt;
    pulse_t            pq, pd;

    mdrop_rx_deser #(.DATA_W(DATA_W), .OSR(OSR)) u_deser (
        .clk(clk), .rst_n(rst_n), .tick(tick16), .rxd(rxd),
        .done(frm_done), .data(frm_data), .ninth(frm_ninth), .stop(frm_stop)
    );

    always_comb begin
        frm_fe    = !frm_stop;
        frm_brk   = (frm_data == '0) && !frm_ninth && !frm_stop;
        frm_tag   = md_mode ? frm_ninth : ^{frm_data, frm_ninth};
        frm_keep  = rx_en || (md_mode && frm_ninth);
        q_full    = (fill_cnt == CNT_W'(DEPTH));
        q_any     = (fill_cnt != '0);
        fifo_push = frm_done && frm_keep;
        fifo_mark = fifo_push && q_full;
        fifo_in   = {frm_brk, frm_fe, frm_tag, 1'b0, frm_data};
        pd.fe     = frm_done && frm_fe;
        pd.brk    = frm_done && frm_brk;
    end

    mdrop_rx_fifo #(.DEPTH(DEPTH), .W(ENT_W), .OVR_BIT(E_OVR)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(fifo_push), .din(fifo_in),
        .pop(rd_pop), .mark(fifo_mark), .dout(head), .fill(fill_cnt)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pq <= '0;
        else        pq <= pd;
    end

    always_comb begin
        rd_stat          = '0;
        rd_data          = '0;
        rd_stat[ST_RDY]  = q_any;
        rd_stat[ST_FULL] = q_full;
        if (q_any) begin
            rd_data         = head[DATA_W-1:0];
            rd_stat[ST_OVR] = head[E_OVR];
            rd_stat[ST_TAG] = head[E_OVR+1];
            rd_stat[ST_FE]  = head[E_OVR+2];
            rd_stat[ST_BRK] = head[E_OVR+3];
        end
    end

    assign fe_pulse  = pq.fe;
    assign brk_pulse = pq.brk;
endmodule

module mdrop_rx_chk #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 3
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       rd_pop,
    input logic                       rx_en,
    input logic                       md_mode,
    input logic [7:0]                 rd_stat,
    input logic [DATA_W-1:0]          rd_data,
    input logic                       fe_pulse,
    input logic                       brk_pulse,
    input logic                       frm_done,
    input logic                       frm_ninth,
    input logic                       frm_stop,
    input logic [$clog2(DEPTH+1)-1:0] fill_cnt
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    // R4
    drop_data_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_done && md_mode && !rx_en && !frm_ninth && !rd_pop)
        |=> (fill_cnt == $past(fill_cnt)));

    // R5
    keep_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_done && rx_en && !rd_pop && (fill_cnt < CNT_W'(DEPTH)))
        |=> (fill_cnt == CNT_W'($past(fill_cnt) + 1'b1)));

    // R7
    fe_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_done && !frm_stop) |=> fe_pulse);

    // R8
    brk_implies_fe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        brk_pulse |-> fe_pulse);

    // R10
    overrun_head_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stat[1] && frm_done && !rd_pop) |=> (rd_stat[1] && $stable(rd_data)));

    // R11
    empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_stat[0] && rd_pop && !frm_done) |=> !rd_stat[0]);
endmodule

bind mdrop_uart_rx mdrop_rx_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .rd_pop(rd_pop), .rx_en(rx_en), .md_mode(md_mode),
    .rd_stat(rd_stat), .rd_data(rd_data), .fe_pulse(fe_pulse),
    .brk_pulse(brk_pulse), .frm_done(frm_done), .frm_ninth(frm_ninth),
    .frm_stop(frm_stop), .fill_cnt(fill_cnt)
);

// File: tb/sim_mdrop_uart_rx.sv
`timescale 1ns/1ps
module sim_mdrop_uart_rx;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick16;
    logic       rxd = 1'b1;
    logic       rx_en = 1'b0;
    logic       md_mode = 1'b1;
    logic       rd_pop = 1'b0;
    logic [7:0] rd_data;
    logic [7:0] rd_stat;
    logic       fe_pulse, brk_pulse;

    int n_chk = 0, n_fail = 0;
    int fe_seen = 0, brk_seen = 0, fe_exp = 0, brk_exp = 0;
    logic [1:0] tcnt = 2'd0;

    // expected queue model
    logic [7:0] m_data [0:3];
    logic [3:0] m_flag [0:3];   // {brk, fe, tag, ovr}
    int         m_n = 0;

    always #2.5 clk = ~clk;

    always_ff @(posedge clk) tcnt <= tcnt + 2'd1;
    assign tick16 = (tcnt == 2'd3);

    always @(negedge clk) begin
        if (fe_pulse)  fe_seen++;
        if (brk_pulse) brk_seen++;
    end

    mdrop_uart_rx u0 (
        .clk(clk), .rst_n(rst_n), .tick16(tick16), .rxd(rxd), .rx_en(rx_en),
        .md_mode(md_mode), .rd_pop(rd_pop), .rd_data(rd_data), .rd_stat(rd_stat),
        .fe_pulse(fe_pulse), .brk_pulse(brk_pulse)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wait_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            while (!tick16) @(negedge clk);
        end
    endtask

    task automatic drive_bit(input logic b);
        @(negedge clk);
        rxd = b;
        wait_ticks(16);
    endtask

    function automatic void model_frame(input logic [7:0] dat, input logic nin, input logic stp);
        logic fe, brk, tag, keep;
        fe   = !stp;
        brk  = (dat == 8'd0) && !nin && !stp;
        tag  = md_mode ? nin : ^{dat, nin};
        keep = rx_en || (md_mode && nin);
        if (fe)  fe_exp++;
        if (brk) brk_exp++;
        if (keep) begin
            if (m_n < 3) begin
                m_data[m_n] = dat;
                m_flag[m_n] = {brk, fe, tag, 1'b0};
                m_n++;
            end else begin
                m_flag[m_n-1][0] = 1'b1;
            end
        end
    endfunction

    task automatic send_frame(input logic [7:0] dat, input logic nin, input logic stp);
        drive_bit(1'b0);
        for (int i = 0; i < 8; i++) drive_bit(dat[i]);
        drive_bit(nin);
        drive_bit(stp);
        @(negedge clk);
        rxd = 1'b1;
        wait_ticks(24);
        model_frame(dat, nin, stp);
        chk(fe_seen == fe_exp, "R7 fe_pulse count", fe_seen, fe_exp);
        chk(brk_seen == brk_exp, "R8 brk_pulse count", brk_seen, brk_exp);
    endtask

    task automatic pop_check(input string req);
        logic [7:0] es;
        @(negedge clk);
        if (m_n == 0) begin
            chk(rd_stat == 8'd0 && rd_data == 8'd0, req, {rd_stat, rd_data}, 0);
        end else begin
            es = {m_flag[0], 2'b00, (m_n == 3), 1'b1};
            chk(rd_stat == es, req, rd_stat, es);
            chk(rd_data == m_data[0], req, rd_data, m_data[0]);
            for (int i = 0; i < 3; i++) begin
                m_data[i] = m_data[i+1];
                m_flag[i] = m_flag[i+1];
            end
            m_n--;
        end
        rd_pop = 1'b1;
        @(negedge clk);
        rd_pop = 1'b0;
    endtask

    task automatic drain(input string req);
        while (m_n > 0) pop_check(req);
        @(negedge clk);
        chk(rd_stat[0] == 1'b0, {req, " empty after drain"}, rd_stat, 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int seed;
        seed = $urandom(32'd5150);
        repeat (4) @(negedge clk);
        // R1 reset state
        chk(rd_stat == 8'd0, "R1 reset stat", rd_stat, 0);
        chk(rd_data == 8'd0, "R1 reset data", rd_data, 0);
        chk(!fe_pulse && !brk_pulse, "R1 reset pulses", {fe_pulse, brk_pulse}, 0);
        rst_n = 1'b1;
        wait_ticks(8);

        // R2 short glitch produces nothing
        @(negedge clk); rxd = 1'b0;
        wait_ticks(4);
        @(negedge clk); rxd = 1'b1;
        wait_ticks(40);
        chk(rd_stat[0] == 1'b0, "R2 glitch ignored", rd_stat, 0);
        chk(fe_seen == 0, "R2 glitch no error", fe_seen, 0);

        // R4 disabled multidrop: data marker dropped, address kept
        md_mode = 1'b1; rx_en = 1'b0;
        send_frame(8'h5A, 1'b0, 1'b1);
        @(negedge clk);
        chk(rd_stat[0] == 1'b0, "R4 data-marked dropped", rd_stat, 0);
        send_frame(8'hA3, 1'b1, 1'b1);
        pop_check("R3 R4 address kept with marker");

        // R7 error pulse on a discarded character
        send_frame(8'h11, 1'b0, 1'b0);
        @(negedge clk);
        chk(rd_stat[0] == 1'b0, "R7 discarded frame not stored", rd_stat, 0);

        // R5 enabled: data marker kept, bit5 clear (R3, no parity)
        rx_en = 1'b1;
        send_frame(8'h01, 1'b0, 1'b1);
        pop_check("R3 R5 data kept, no parity check");

        // R6 plain mode parity
        md_mode = 1'b0;
        send_frame(8'h07, 1'b1, 1'b1);
        send_frame(8'h07, 1'b0, 1'b1);
        drain("R6 parity flag");
        rx_en = 1'b0;
        send_frame(8'h3C, 1'b1, 1'b1);
        @(negedge clk);
        chk(rd_stat[0] == 1'b0, "R6 disabled plain mode stores nothing", rd_stat, 0);

        // R8 break, line held low, then normal frame
        rx_en = 1'b1; md_mode = 1'b1;
        drive_bit(1'b0);
        for (int i = 0; i < 10; i++) drive_bit(1'b0);
        drive_bit(1'b0);
        drive_bit(1'b0);
        @(negedge clk); rxd = 1'b1;
        wait_ticks(24);
        model_frame(8'h00, 1'b0, 1'b0);
        chk(brk_seen == brk_exp, "R8 single break", brk_seen, brk_exp);
        send_frame(8'hC5, 1'b1, 1'b1);
        drain("R8 break entry then next frame");

        // R9 R10 overrun with five frames
        send_frame(8'h10, 1'b0, 1'b1);
        send_frame(8'h20, 1'b1, 1'b1);
        send_frame(8'h30, 1'b0, 1'b1);
        @(negedge clk);
        chk(rd_stat[1] == 1'b1, "R9 full flag", rd_stat, 8'h03);
        send_frame(8'h40, 1'b0, 1'b1);
        send_frame(8'h50, 1'b0, 1'b1);
        drain("R9 R10 order and overrun");

        // R11 pop when empty, then a frame reads back intact
        pop_check("R11 empty pop");
        pop_check("R11 empty pop again");
        send_frame(8'h99, 1'b1, 1'b1);
        pop_check("R11 queue intact after empty pops");

        // constrained random bursts
        for (int b = 0; b < 22; b++) begin
            int nf;
            nf = 1 + ($urandom % 5);
            for (int f = 0; f < nf; f++) begin
                logic [7:0] dat;
                logic nin, stp;
                md_mode = ($urandom % 4) != 0;
                rx_en   = ($urandom % 2) != 0;
                dat     = (($urandom % 6) == 0) ? 8'h00 : 8'($urandom);
                nin     = ($urandom % 2) != 0;
                stp     = ($urandom % 8) != 0;
                send_frame(dat, nin, stp);
            end
            drain("R3 R4 R5 R6 R9 R10 random");
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule